// File: doc/BRIEF.md
# Serial Audio Link Power-Down and Test-Mode Controller

This block is the control side of a codec attached to a frame-based serial audio link of the AC'97 kind. It runs on the bit clock. It deframes the serial data that the controller sends, picks out a register write carried in the command and data slots, and watches for one particular write: a write that sets the link power-down bit. When that write arrives, the block stops the bit clock gate and holds the codec's serial return data low.

It also chooses the operating mode when the link reset is released. The level of the controller's serial data line in that first released clock decides the mode. A low level gives normal operation. A high level gives a test mode in which both link outputs of the codec float. Test mode is left only by another reset. A cold reset also ends a power-down.

Top module: `ac_link_pwr_ctrl`

## Requirements
- R1: In the first clock in which `link_rst_n` is sampled high after being low, a high `sdata_out` selects test mode. `link_test_mode` becomes 1, and `bit_clk_oe` and `sdin_oe` become 0 right after that same clock edge, with no further register stage.
- R2: In that same release clock, a low `sdata_out` selects normal mode whatever the level of `sync`. After that edge `bit_clk_run`, `bit_clk_oe` and `sdin_oe` are all 1.
- R3: Test mode persists through any link traffic for as long as `link_rst_n` stays high. A later reset whose release sees `sdata_out` low returns the block to normal mode.
- R4: In test mode no frame can set `link_pdown`.
- R5: While `link_rst_n` is low, `link_test_mode`, `link_pdown`, `bit_clk_run` and `sdin_o` are 0, and both output enables are 1 (the outputs drive low).
- R6: A clock that samples `sync` high after `sync` was low is bit 0 of a 256-bit frame. This happens even in the middle of a frame, where it restarts the alignment. The 16 tag bits come first and the 20-bit slots follow, each sent MSB first. Frame bit 1 flags slot 1 as valid and frame bit 2 flags slot 2 as valid. Slot 1 occupies bits 16 to 35 and slot 2 occupies bits 36 to 55.
- R7: A power-down write is a frame with both slot flags set, slot 1 bit 19 = 0 (write), slot 1 bits 18:12 = 0x20, and slot 2 bit 16 = 1 (data bit 12 of the 16-bit data in slot 2 bits 19:4). After such a frame, `link_pdown` is still 0 after the edge that samples frame bit 55 and is 1 after the next edge.
- R8: No power-down occurs if any one of the R7 conditions is missing: slot 1 flag clear, slot 2 flag clear, read flag set, another index, or data bit 12 clear.
- R9: While `link_pdown` is 1, `bit_clk_run` and `sdin_o` are 0. `link_pdown` stays 1 until `link_rst_n` goes low. A release with `sdata_out` low then restores a running clock.
- R10: In normal mode without power-down, `sdin_o` equals `codec_sdin` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| link_rst_n | input | 1 | Link cold reset, active low |
| sync | input | 1 | Frame sync from the controller |
| sdata_out | input | 1 | Serial data from the controller |
| codec_sdin | input | 1 | Return data from the codec core |
| bit_clk_oe | output | 1 | Output enable of the bit clock pin |
| bit_clk_run | output | 1 | Bit clock gate, 1 = clock toggles |
| sdin_o | output | 1 | Serial return data driven to the link |
| sdin_oe | output | 1 | Output enable of the return data pin |
| link_test_mode | output | 1 | Test mode is active |
| link_pdown | output | 1 | Link is powered down |

## Verification
A table of frames is sent, each after a cold reset into normal mode. One frame is the exact power-down write. Others each break a single condition (read flag, index 0x22, data bit 12 clear with all other data bits set, either slot flag clear). Others keep the bit set but add unrelated data bits. Together they show that each field is decoded at its own position and that nothing else counts. Each frame checks `link_pdown` at the two edges around the end of slot 2, which pins down the shutdown latency. Directed cases then drive the mode choice at reset release with `sdata_out` high, with only `sync` high, and with all inputs low. They also send a power-down write in test mode and restart a frame partway through, which shows the frame counter is realigned by sync rather than running free.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int SLOT_COUNT = 12;
    localparam int FRAME_BITS = TAG_BITS + SLOT_COUNT * SLOT_BITS;
    localparam int IDX_BITS   = 7;
    localparam int DATA_BITS  = 16;
    localparam logic [IDX_BITS-1:0] PD_INDEX = 7'h20;
    localparam int PD_DATA_BIT = 12;

    typedef logic [SLOT_BITS-1:0] slot_t;

    // command captured from one frame
    typedef struct packed {
        logic  cmd_ok;
        logic  dat_ok;
        slot_t cmd;
        slot_t dat;
    } wr_req_t;

    typedef enum logic [1:0] {
        M_RESET  = 2'd0,
        M_NORMAL = 2'd1,
        M_TEST   = 2'd2
    } mode_e;

    function automatic logic is_pd_write(wr_req_t r);
        logic idx_hit;
        idx_hit = (r.cmd[SLOT_BITS-2 -: IDX_BITS] == PD_INDEX);
        return r.cmd_ok && r.dat_ok && !r.cmd[SLOT_BITS-1] && idx_hit
               && r.dat[SLOT_BITS - DATA_BITS + PD_DATA_BIT];
    endfunction

endpackage

// File: rtl/link_deframer.sv
module link_deframer
    import aclk_pkg::*;
#(
    parameter int TAGB   = TAG_BITS,
    parameter int SLOTB  = SLOT_BITS,
    parameter int FRAMEB = FRAME_BITS
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sync,
    input  logic    sdo,
    output logic    req_valid,
    output wr_req_t req
);
    localparam int CW      = $clog2(FRAMEB);
    localparam int S1_LAST = TAGB + SLOTB - 1;
    localparam int S2_LAST = TAGB + 2 * SLOTB - 1;

    logic             sync_q;
    logic             in_frame;
    logic [CW-1:0]    cnt;
    logic [SLOTB-2:0] shreg;
    slot_t            s1_q;
    logic             v1_q, v2_q;

    logic          sync_rise, live;
    logic [CW-1:0] pos;
    slot_t         cur_slot;

    assign sync_rise = sync && !sync_q;
    assign live      = sync_rise || in_frame;
    assign pos       = sync_rise ? '0 : cnt;
    assign cur_slot  = {shreg, sdo};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= 1'b0;
            in_frame  <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            s1_q      <= '0;
            v1_q      <= 1'b0;
            v2_q      <= 1'b0;
            req_valid <= 1'b0;
            req       <= '0;
        end else begin
            sync_q    <= sync;
            req_valid <= 1'b0;
            if (live) begin
                shreg    <= cur_slot[SLOTB-2:0];
                cnt      <= pos + 1'b1;
                in_frame <= (pos != CW'(FRAMEB - 1));
                if (pos == CW'(1)) v1_q <= sdo;
                if (pos == CW'(2)) v2_q <= sdo;
                if (pos == CW'(S1_LAST)) s1_q <= cur_slot;
                if (pos == CW'(S2_LAST)) begin
                    req.cmd_ok <= v1_q;
                    req.dat_ok <= v2_q;
                    req.cmd    <= s1_q;
                    req.dat    <= cur_slot;
                    req_valid  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/link_mode_ctrl.sv
module link_mode_ctrl
    import aclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sdo,
    input  logic    req_valid,
    input  wr_req_t req,
    output mode_e   mode,
    output logic    pdown
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= M_RESET;
            pdown <= 1'b0;
        end else begin
            if (mode == M_RESET)
                mode <= sdo ? M_TEST : M_NORMAL;
            if (mode == M_NORMAL && req_valid && is_pd_write(req))
                pdown <= 1'b1;
        end
    end

endmodule

// File: rtl/link_out_stage.sv
module link_out_stage
    import aclk_pkg::*;
(
    input  mode_e mode,
    input  logic  pdown,
    input  logic  codec_sdin,
    output logic  bit_clk_oe,
    output logic  bit_clk_run,
    output logic  sdin_o,
    output logic  sdin_oe
);
    logic running;

    assign running     = (mode == M_NORMAL) && !pdown;
    assign bit_clk_oe  = (mode != M_TEST);
    assign sdin_oe     = (mode != M_TEST);
    assign bit_clk_run = running;
    assign sdin_o      = running && codec_sdin;

endmodule

// File: rtl/ac_link_pwr_ctrl.sv
module ac_link_pwr_ctrl
    import aclk_pkg::*;
(
    input  logic clk,
    input  logic link_rst_n,
    input  logic sync,
    input  logic sdata_out,
    input  logic codec_sdin,
    output logic bit_clk_oe,
    output logic bit_clk_run,
    output logic sdin_o,
    output logic sdin_oe,
    output logic link_test_mode,
    output logic link_pdown
);
    logic    rst;
    logic    req_valid;
    wr_req_t req;
    mode_e   mode;

    assign rst = !link_rst_n;

    link_deframer u_deframer (
        .clk       (clk),
        .rst       (rst),
        .sync      (sync),
        .sdo       (sdata_out),
        .req_valid (req_valid),
        .req       (req)
    );

    link_mode_ctrl u_mode (
        .clk       (clk),
        .rst       (rst),
        .sdo       (sdata_out),
        .req_valid (req_valid),
        .req       (req),
        .mode      (mode),
        .pdown     (link_pdown)
    );

    link_out_stage u_out (
        .mode        (mode),
        .pdown       (link_pdown),
        .codec_sdin  (codec_sdin),
        .bit_clk_oe  (bit_clk_oe),
        .bit_clk_run (bit_clk_run),
        .sdin_o      (sdin_o),
        .sdin_oe     (sdin_oe)
    );

    assign link_test_mode = (mode == M_TEST);

endmodule

// File: rtl/ac_link_pwr_ctrl_chk.sv
module ac_link_pwr_ctrl_chk (
    input logic clk,
    input logic link_rst_n,
    input logic sdata_out,
    input logic codec_sdin,
    input logic bit_clk_oe,
    input logic bit_clk_run,
    input logic sdin_o,
    input logic sdin_oe,
    input logic link_test_mode,
    input logic link_pdown
);
    p_test_entry_r1: assert property (@(posedge clk) disable iff (!link_rst_n)
        (!$past(link_rst_n) && sdata_out) |=> (link_test_mode && !bit_clk_oe && !sdin_oe));

    p_normal_entry_r2: assert property (@(posedge clk) disable iff (!link_rst_n)
        (!$past(link_rst_n) && !sdata_out) |=> (bit_clk_run && bit_clk_oe && sdin_oe));

    p_test_sticky_r3: assert property (@(posedge clk) disable iff (!link_rst_n)
        link_test_mode |=> link_test_mode);

    p_test_no_pd_r4: assert property (@(posedge clk) disable iff (!link_rst_n)
        link_test_mode |-> !link_pdown);

    p_pd_gates_r9: assert property (@(posedge clk) disable iff (!link_rst_n)
        link_pdown |-> (!bit_clk_run && !sdin_o));

    p_pd_sticky_r9: assert property (@(posedge clk) disable iff (!link_rst_n)
        link_pdown |=> link_pdown);

    p_pass_r10: assert property (@(posedge clk) disable iff (!link_rst_n)
        bit_clk_run |-> (sdin_o == codec_sdin));

endmodule

bind ac_link_pwr_ctrl ac_link_pwr_ctrl_chk u_chk (
    .clk            (clk),
    .link_rst_n     (link_rst_n),
    .sdata_out      (sdata_out),
    .codec_sdin     (codec_sdin),
    .bit_clk_oe     (bit_clk_oe),
    .bit_clk_run    (bit_clk_run),
    .sdin_o         (sdin_o),
    .sdin_oe        (sdin_oe),
    .link_test_mode (link_test_mode),
    .link_pdown     (link_pdown)
);

// File: tb/ac_link_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module ac_link_pwr_ctrl_tb_top;

    logic clk = 1'b0;
    logic link_rst_n = 1'b0;
    logic sync = 1'b0;
    logic sdata_out = 1'b0;
    logic codec_sdin = 1'b0;
    logic bit_clk_oe, bit_clk_run, sdin_o, sdin_oe, link_test_mode, link_pdown;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    ac_link_pwr_ctrl dut_i (
        .clk            (clk),
        .link_rst_n     (link_rst_n),
        .sync           (sync),
        .sdata_out      (sdata_out),
        .codec_sdin     (codec_sdin),
        .bit_clk_oe     (bit_clk_oe),
        .bit_clk_run    (bit_clk_run),
        .sdin_o         (sdin_o),
        .sdin_oe        (sdin_oe),
        .link_test_mode (link_test_mode),
        .link_pdown     (link_pdown)
    );

    // vector: {slot1 flag, slot2 flag, slot1[19:0], slot2[19:0], expected power-down}
    localparam int NVEC = 8;
    localparam logic [42:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 20'h20000, 20'h10000, 1'b1},  // R7 exact write
        {1'b1, 1'b1, 20'hA0000, 20'h10000, 1'b0},  // R8 read flag
        {1'b1, 1'b1, 20'h22000, 20'h10000, 1'b0},  // R8 other index
        {1'b1, 1'b1, 20'h20000, 20'hEFFF0, 1'b0},  // R8 data bit 12 clear
        {1'b0, 1'b1, 20'h20000, 20'h10000, 1'b0},  // R8 slot1 flag clear
        {1'b1, 1'b0, 20'h20000, 20'h10000, 1'b0},  // R8 slot2 flag clear
        {1'b1, 1'b1, 20'h20000, 20'hFFFF0, 1'b1},  // R7 all data bits
        {1'b1, 1'b1, 20'h20FFF, 20'h1000F, 1'b1}   // R7 unrelated bits set
    };

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // hold reset, then release with the given levels on sync and sdata_out
    task automatic cold_reset(input logic sdo_v, input logic sync_v);
        @(negedge clk);
        link_rst_n = 1'b0; sync = 1'b0; sdata_out = 1'b0;
        repeat (3) @(negedge clk);
        sync = sync_v; sdata_out = sdo_v; link_rst_n = 1'b1;
        @(negedge clk);
        sync = 1'b0; sdata_out = 1'b0;
    endtask

    task automatic send_frame(input logic t1, input logic t2, input logic [19:0] s1,
                              input logic [19:0] s2, input int nbits,
                              input logic chk, input logic exp, input string what);
        logic [255:0] f;
        f = {1'b1, t1, t2, 13'b0, s1, s2, 200'b0};
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (chk && i == 56) check(link_pdown, 1'b0, {what, " before end of slot 2"});
            if (chk && i == 57) check(link_pdown, exp, {what, " after end of slot 2"});
            sync = (i < 16);
            sdata_out = f[255-i];
        end
        @(negedge clk);
        sync = 1'b0; sdata_out = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        // R5 reset state
        repeat (3) @(negedge clk);
        check(link_test_mode, 1'b0, "R5 test flag in reset");
        check(link_pdown, 1'b0, "R5 pdown in reset");
        check(bit_clk_run, 1'b0, "R5 clock gate in reset");
        check(bit_clk_oe, 1'b1, "R5 clock enable in reset");
        check(sdin_oe, 1'b1, "R5 sdin enable in reset");

        // R6 R7 R8 R9 table walk
        for (int v = 0; v < NVEC; v++) begin
            cold_reset(1'b0, 1'b0);
            codec_sdin = 1'b1;
            send_frame(VEC[v][42], VEC[v][41], VEC[v][40:21], VEC[v][20:1], 256,
                       1'b1, VEC[v][0], $sformatf("R7/R8 vector %0d", v));
            check(bit_clk_run, !VEC[v][0], $sformatf("R9 clock gate vector %0d", v));
            check(sdin_o, !VEC[v][0], $sformatf("R9 sdin vector %0d", v));
            codec_sdin = 1'b0;
        end

        // R9 power-down is sticky, then cleared by cold reset
        send_frame(1'b1, 1'b1, 20'h20000, 20'h00000, 256, 1'b0, 1'b0, "");
        check(link_pdown, 1'b1, "R9 pdown sticky");
        @(negedge clk); link_rst_n = 1'b0;
        @(negedge clk);
        check(link_pdown, 1'b0, "R5 pdown cleared by reset");
        cold_reset(1'b0, 1'b0);
        check(bit_clk_run, 1'b1, "R9 clock restored after reset");

        // R10 passthrough
        codec_sdin = 1'b1; #1;
        check(sdin_o, 1'b1, "R10 sdin follows high");
        codec_sdin = 1'b0; #1;
        check(sdin_o, 1'b0, "R10 sdin follows low");

        // R1 test mode entry
        cold_reset(1'b1, 1'b0);
        check(link_test_mode, 1'b1, "R1 test flag");
        check(bit_clk_oe, 1'b0, "R1 clock enable off");
        check(sdin_oe, 1'b0, "R1 sdin enable off");
        // R3 R4 traffic in test mode
        send_frame(1'b1, 1'b1, 20'h20000, 20'h10000, 256, 1'b1, 1'b0, "R4 write in test mode");
        check(link_test_mode, 1'b1, "R3 test mode persists");
        check(bit_clk_oe, 1'b0, "R3 clock enable still off");
        // R3 exit with all low
        cold_reset(1'b0, 1'b0);
        check(link_test_mode, 1'b0, "R3 test mode left");
        check(bit_clk_oe, 1'b1, "R3 clock enable back");

        // R2 sync high alone keeps normal mode
        cold_reset(1'b0, 1'b1);
        check(link_test_mode, 1'b0, "R2 sync-only release");
        check(bit_clk_run, 1'b1, "R2 clock runs");
        check(sdin_oe, 1'b1, "R2 sdin enable");

        // R6 mid-frame restart
        cold_reset(1'b0, 1'b0);
        send_frame(1'b1, 1'b1, 20'h20000, 20'h10000, 20, 1'b0, 1'b0, "");
        send_frame(1'b1, 1'b1, 20'h20000, 20'h10000, 256, 1'b1, 1'b1, "R6 restarted frame");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule